// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact 32-bit in-order processor core. Each instruction moves through five stages in a fixed order: fetch, decode, execute, memory access and writeback. The core holds its own instruction and data memories, a 32-entry register file, an ALU and the pipeline registers between the stages. The instruction image is a parameter, so the surrounding design or a bench fixes the program at elaboration. After reset, the core runs that program from address zero. Two combinational debug ports let an observer read any register or any data-memory word at any time.

The core executes twelve integer instructions of a classic 32-bit load/store RISC encoding. The opcode is in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, shamt in bits 10:6, the function code in bits 5:0 and the immediate in bits 15:0. Read-after-write dependencies between ALU instructions are resolved by operand forwarding, with no lost cycles. Only a load followed at once by a consumer of the loaded value costs a single bubble.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous reset clears the PC to 0, turns every pipeline stage into a no-operation and clears all registers, so every register reads 0 until the first writeback.
- R2: Fetch reads the word at PC/4 and adds 4 to the PC every cycle that is not stalled. Words beyond the image read as 0, which is a no-operation. Without stalls, the instruction at word i writes its register on the (i+5)-th rising edge after reset is released.
- R3: The immediate instructions are ADDI (opcode 0x08), SLTI (0x0a), ANDI (0x0c) and ORI (0x0d). Each writes rt. ADDI and SLTI sign-extend the 16-bit immediate, and ANDI and ORI zero-extend it. SLTI compares as signed.
- R4: With opcode 0, the register instructions are ADD (function 0x20), SUB (0x22), AND (0x24), OR (0x25), XOR (0x26) and SLT (0x2a, signed). Each writes rd from rs and rt.
- R5: SLL (function 0x00) and SRL (0x02) shift rt by the amount in bits 10:6, filling with zeros, and write rd.
- R6: LW (opcode 0x23) and SW (0x2b) use the address rs plus the sign-extended immediate. The byte address divided by 4 selects the data word. Only these two instructions touch data memory.
- R7: A result consumed by the next instruction or the one after it is forwarded into execute with no stall.
- R8: When both older in-flight instructions write the source register, the younger one (in the execute/memory register) supplies the operand.
- R9: Register 0 always reads 0. A write to it is dropped and is never forwarded.
- R10: A load followed directly by an instruction that reads the loaded register inserts exactly one bubble. The loaded value is then forwarded from the memory/writeback register, and this includes the store-data operand of a SW.
- R11: A register written in writeback is seen by an instruction decoding in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_reg_val | output | 32 | Content of the selected register (0 for index 0) |
| dbg_mem_sel | input | $clog2(DMEM_WORDS) | Word index for the data-memory debug read |
| dbg_mem_val | output | 32 | Content of the selected data word |

## Verification
The embedded assertions watch the control side on every cycle:
- the PC advances by 4 whenever no interlock is raised;
- a load-use interlock holds the decode instruction and injects exactly one bubble, and never fires twice in a row;
- no writeback ever targets register 0;
- load and store never coincide in the memory stage.

Only the bench's program can show that the data path computes the right values. It checks the sign and zero extensions, signed comparison, shift amounts, the forwarding priority, the store-after-load data path and the cycle on which results land. It observes these through the debug ports at exact cycles.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int IMEM_WORDS = 32,
  parameter int DMEM_WORDS = 32,
  parameter logic [IMEM_WORDS*32-1:0] PROG = '0,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      dbg_reg_sel,
  output logic [31:0]     dbg_reg_val,
  input  logic [DA_W-1:0] dbg_mem_sel,
  output logic [31:0]     dbg_mem_val
);
  typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLT, A_SLL, A_SRL} alu_t;

  logic [31:0] rf [32];
  logic [31:0] dmem [DMEM_WORDS];

  // fetch
  logic [31:0] pc, id_ir, if_word;
  logic        stall;
  assign if_word = (pc[31:IA_W+2] == '0) ? PROG[pc[IA_W+1:2]*32 +: 32] : 32'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      id_ir <= '0;
    end else if (!stall) begin
      pc    <= pc + 32'd4;
      id_ir <= if_word;
    end
  end

  // decode
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, sh;
  logic [15:0] imm16;
  assign {op, rs, rt, rd, sh, fn} = id_ir;
  assign imm16 = id_ir[15:0];

  alu_t        d_alu;
  logic        d_imm, d_zext, d_we, d_ld, d_st, use_rs, use_rt;
  logic [4:0]  d_dst;
  always_comb begin
    d_alu = A_ADD; d_imm = 1'b0; d_zext = 1'b0; d_we = 1'b0;
    d_ld = 1'b0; d_st = 1'b0; d_dst = rt; use_rs = 1'b1; use_rt = 1'b0;
    case (op)
      6'h00: begin
        d_dst = rd; use_rt = 1'b1; d_we = 1'b1;
        case (fn)
          6'h20: d_alu = A_ADD;
          6'h22: d_alu = A_SUB;
          6'h24: d_alu = A_AND;
          6'h25: d_alu = A_OR;
          6'h26: d_alu = A_XOR;
          6'h2a: d_alu = A_SLT;
          6'h00: begin d_alu = A_SLL; use_rs = 1'b0; end
          6'h02: begin d_alu = A_SRL; use_rs = 1'b0; end
          default: begin d_we = 1'b0; use_rt = 1'b0; end
        endcase
      end
      6'h08: begin d_imm = 1'b1; d_we = 1'b1; end
      6'h0a: begin d_imm = 1'b1; d_we = 1'b1; d_alu = A_SLT; end
      6'h0c: begin d_imm = 1'b1; d_we = 1'b1; d_zext = 1'b1; d_alu = A_AND; end
      6'h0d: begin d_imm = 1'b1; d_we = 1'b1; d_zext = 1'b1; d_alu = A_OR; end
      6'h23: begin d_imm = 1'b1; d_we = 1'b1; d_ld = 1'b1; end
      6'h2b: begin d_imm = 1'b1; d_st = 1'b1; use_rt = 1'b1; end
      default: use_rs = 1'b0;
    endcase
  end

  logic [31:0] wb_val;
  logic [4:0]  wb_dst;
  logic        wb_we;
  logic [31:0] rd_a, rd_b;
  assign rd_a = (rs == 5'd0) ? 32'h0 : (wb_we && wb_dst == rs) ? wb_val : rf[rs];
  assign rd_b = (rt == 5'd0) ? 32'h0 : (wb_we && wb_dst == rt) ? wb_val : rf[rt];

  alu_t        ex_alu;
  logic [31:0] ex_a, ex_b, ex_immv;
  logic [4:0]  ex_rs, ex_rt, ex_dst, ex_sh;
  logic        ex_imm, ex_we, ex_ld, ex_st;

  assign stall = ex_ld && ex_we &&
                 ((use_rs && ex_dst == rs) || (use_rt && ex_dst == rt));

  always_ff @(posedge clk) begin
    if (rst || stall) begin
      ex_alu <= A_ADD; ex_a <= '0; ex_b <= '0; ex_immv <= '0;
      ex_rs <= '0; ex_rt <= '0; ex_dst <= '0; ex_sh <= '0;
      ex_imm <= 1'b0; ex_we <= 1'b0; ex_ld <= 1'b0; ex_st <= 1'b0;
    end else begin
      ex_alu  <= d_alu;
      ex_a    <= rd_a;
      ex_b    <= rd_b;
      ex_immv <= d_zext ? {16'h0, imm16} : {{16{imm16[15]}}, imm16};
      ex_rs   <= rs;
      ex_rt   <= rt;
      ex_dst  <= d_dst;
      ex_sh   <= sh;
      ex_imm  <= d_imm;
      ex_we   <= d_we && (d_dst != 5'd0);
      ex_ld   <= d_ld;
      ex_st   <= d_st;
    end
  end

  // execute with forwarding
  logic [31:0] mem_res, mem_sd;
  logic [4:0]  mem_dst;
  logic        mem_we, mem_ld, mem_st;
  logic [31:0] fa, fb, opb, alu_y;

  assign fa = (mem_we && mem_dst == ex_rs) ? mem_res :
              (wb_we  && wb_dst  == ex_rs) ? wb_val  : ex_a;
  assign fb = (mem_we && mem_dst == ex_rt) ? mem_res :
              (wb_we  && wb_dst  == ex_rt) ? wb_val  : ex_b;
  assign opb = ex_imm ? ex_immv : fb;

  always_comb begin
    case (ex_alu)
      A_SUB:   alu_y = fa - opb;
      A_AND:   alu_y = fa & opb;
      A_OR:    alu_y = fa | opb;
      A_XOR:   alu_y = fa ^ opb;
      A_SLT:   alu_y = {31'h0, $signed(fa) < $signed(opb)};
      A_SLL:   alu_y = fb << ex_sh;
      A_SRL:   alu_y = fb >> ex_sh;
      default: alu_y = fa + opb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_res <= '0; mem_sd <= '0; mem_dst <= '0;
      mem_we <= 1'b0; mem_ld <= 1'b0; mem_st <= 1'b0;
    end else begin
      mem_res <= alu_y; mem_sd <= fb; mem_dst <= ex_dst;
      mem_we <= ex_we; mem_ld <= ex_ld; mem_st <= ex_st;
    end
  end

  // memory access
  logic [DA_W-1:0] m_idx;
  assign m_idx = mem_res[DA_W+1:2];

  always_ff @(posedge clk)
    if (!rst && mem_st) dmem[m_idx] <= mem_sd;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_val <= '0; wb_dst <= '0; wb_we <= 1'b0;
    end else begin
      wb_val <= mem_ld ? dmem[m_idx] : mem_res;
      wb_dst <= mem_dst;
      wb_we  <= mem_we;
    end
  end

  // writeback
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (wb_we) begin
      rf[wb_dst] <= wb_val;
    end
  end

  assign dbg_reg_val = (dbg_reg_sel == 5'd0) ? 32'h0 : rf[dbg_reg_sel];
  assign dbg_mem_val = dmem[dbg_mem_sel];

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> pc == $past(pc) + 32'd4);
  // R10
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ex_we && !ex_ld && !ex_st);
  // R10
  single_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
  // R10
  hold_ir_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(id_ir) && $stable(pc));
  // R9
  no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> wb_dst != 5'd0);
  // R6
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_ld && mem_st));
endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/100ps
module pipe5_core_bench;
  localparam int NW = 32;

  function automatic logic [31:0] fr(input logic [4:0] s, input logic [4:0] t,
                                     input logic [4:0] d, input logic [4:0] a,
                                     input logic [5:0] f);
    return {6'h00, s, t, d, a, f};
  endfunction
  function automatic logic [31:0] fi(input logic [5:0] o, input logic [4:0] s,
                                     input logic [4:0] t, input logic [15:0] k);
    return {o, s, t, k};
  endfunction

  function automatic logic [NW*32-1:0] build();
    logic [NW*32-1:0] p;
    p = '0;
    p[ 0*32 +: 32] = fi(6'h08, 5'd0, 5'd1, 16'd5);
    p[ 1*32 +: 32] = fi(6'h08, 5'd0, 5'd2, 16'hFFFD);
    p[ 2*32 +: 32] = fr(5'd1, 5'd2, 5'd3, 5'd0, 6'h20);
    p[ 3*32 +: 32] = fr(5'd3, 5'd1, 5'd4, 5'd0, 6'h22);
    p[ 4*32 +: 32] = fi(6'h0d, 5'd0, 5'd5, 16'h8001);
    p[ 5*32 +: 32] = fi(6'h0c, 5'd2, 5'd6, 16'hFFF0);
    p[ 6*32 +: 32] = fi(6'h0a, 5'd2, 5'd7, 16'hFFFF);
    p[ 7*32 +: 32] = fr(5'd1, 5'd2, 5'd8, 5'd0, 6'h2a);
    p[ 8*32 +: 32] = fr(5'd5, 5'd6, 5'd9, 5'd0, 6'h26);
    p[ 9*32 +: 32] = fr(5'd9, 5'd5, 5'd10, 5'd0, 6'h24);
    p[10*32 +: 32] = fr(5'd10, 5'd4, 5'd11, 5'd0, 6'h25);
    p[11*32 +: 32] = fr(5'd0, 5'd1, 5'd12, 5'd4, 6'h00);
    p[12*32 +: 32] = fr(5'd0, 5'd2, 5'd13, 5'd28, 6'h02);
    p[13*32 +: 32] = fi(6'h2b, 5'd0, 5'd3, 16'd8);
    p[14*32 +: 32] = fi(6'h2b, 5'd0, 5'd12, 16'd12);
    p[15*32 +: 32] = fi(6'h23, 5'd0, 5'd14, 16'd8);
    p[16*32 +: 32] = fr(5'd14, 5'd14, 5'd15, 5'd0, 6'h20);
    p[17*32 +: 32] = fi(6'h08, 5'd0, 5'd16, 16'd7);
    p[18*32 +: 32] = fi(6'h08, 5'd16, 5'd16, 16'd1);
    p[19*32 +: 32] = fi(6'h08, 5'd16, 5'd16, 16'd10);
    p[20*32 +: 32] = fr(5'd16, 5'd16, 5'd17, 5'd0, 6'h20);
    p[21*32 +: 32] = fi(6'h08, 5'd1, 5'd0, 16'd9);
    p[22*32 +: 32] = fr(5'd0, 5'd1, 5'd18, 5'd0, 6'h20);
    p[23*32 +: 32] = fi(6'h08, 5'd0, 5'd19, 16'd100);
    p[26*32 +: 32] = fr(5'd19, 5'd0, 5'd20, 5'd0, 6'h20);
    p[27*32 +: 32] = fi(6'h23, 5'd0, 5'd21, 16'd12);
    p[28*32 +: 32] = fi(6'h2b, 5'd0, 5'd21, 16'd16);
    p[29*32 +: 32] = fi(6'h2b, 5'd0, 5'd17, 16'd124);
    p[30*32 +: 32] = fi(6'h23, 5'd0, 5'd22, 16'd124);
    return p;
  endfunction
  localparam logic [NW*32-1:0] PROG = build();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val;
  logic [4:0]  dbg_mem_sel = '0;
  logic [31:0] dbg_mem_val;

  pipe5_core #(.IMEM_WORDS(NW), .DMEM_WORDS(32), .PROG(PROG)) u_pipe5_core (
    .clk(clk), .rst(rst),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val));

  always #2.5 clk = ~clk;

  typedef struct {
    int          cyc;
    bit          is_mem;
    logic [4:0]  idx;
    logic [31:0] val;
    string       req;
  } item_t;
  item_t q[$];

  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic expect_at(input int c, input bit m, input logic [4:0] i,
                           input logic [31:0] v, input string r);
    item_t it;
    it.cyc = c; it.is_mem = m; it.idx = i; it.val = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic drive();
    // R1 reset state
    expect_at(0, 0, 5'd1, 32'h0, "R1");
    expect_at(1, 0, 5'd2, 32'h0, "R1");
    // R2 write timing of word 0 and word 2 (no stall)
    expect_at(4, 0, 5'd1, 32'h0, "R2");
    expect_at(5, 0, 5'd1, 32'd5, "R2");
    expect_at(6, 0, 5'd3, 32'h0, "R7");
    expect_at(7, 0, 5'd3, 32'd2, "R7");
    // R10 one bubble after the first load-use
    expect_at(25, 0, 5'd17, 32'h0, "R10");
    expect_at(26, 0, 5'd17, 32'd36, "R10");
    // R10 second load-use (store data), total two bubbles
    expect_at(36, 0, 5'd22, 32'h0, "R10");
    expect_at(37, 0, 5'd22, 32'd36, "R10");
    // final state
    expect_at(50, 0, 5'd2,  32'hFFFFFFFD, "R3");
    expect_at(51, 0, 5'd3,  32'd2,        "R7");
    expect_at(52, 0, 5'd4,  32'hFFFFFFFD, "R4");
    expect_at(53, 0, 5'd5,  32'h00008001, "R3");
    expect_at(54, 0, 5'd6,  32'h0000FFF0, "R3");
    expect_at(55, 0, 5'd7,  32'd1,        "R3");
    expect_at(56, 0, 5'd8,  32'd0,        "R4");
    expect_at(57, 0, 5'd9,  32'h00007FF1, "R4");
    expect_at(58, 0, 5'd10, 32'd1,        "R4");
    expect_at(59, 0, 5'd11, 32'hFFFFFFFD, "R4");
    expect_at(60, 0, 5'd12, 32'h00000050, "R5");
    expect_at(61, 0, 5'd13, 32'h0000000F, "R5");
    expect_at(62, 0, 5'd14, 32'd2,        "R6");
    expect_at(63, 0, 5'd15, 32'd4,        "R10");
    expect_at(64, 0, 5'd16, 32'd18,       "R7");
    expect_at(65, 0, 5'd17, 32'd36,       "R8");
    expect_at(66, 0, 5'd0,  32'h0,        "R9");
    expect_at(67, 0, 5'd18, 32'd5,        "R9");
    expect_at(68, 0, 5'd20, 32'd100,      "R11");
    expect_at(69, 0, 5'd21, 32'h00000050, "R6");
    expect_at(70, 1, 5'd2,  32'd2,        "R6");
    expect_at(71, 1, 5'd3,  32'h00000050, "R6");
    expect_at(72, 1, 5'd4,  32'h00000050, "R10");
    expect_at(73, 1, 5'd31, 32'd36,       "R6");
  endtask

  initial drive();

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    while (q.size() > 0) begin
      if (q[0].cyc == cyc) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        if (it.is_mem) dbg_mem_sel = it.idx; else dbg_reg_sel = it.idx;
        #1;
        got = it.is_mem ? dbg_mem_val : dbg_reg_val;
        checks++;
        if (got !== it.val) begin
          fails++;
          $display("FAIL %s cycle %0d %s[%0d]: got %h expected %h",
                   it.req, it.cyc, it.is_mem ? "mem" : "reg", it.idx, got, it.val);
        end
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule